// File: doc/BRIEF.md
# Hysteretic Digital Lock Detector

This block decides whether a phase-locked loop is in lock by looking at its phase detector once per detector cycle. During each cycle it counts the sampling-clock ticks on which either the UP or the DOWN correction pulse is high. That count is the cycle's phase error. At the cycle boundary, marked by a one-tick reference strobe, the error is compared with a threshold held on an input bus.

The lock flag uses asymmetric hysteresis. It rises only after a run of consecutive in-threshold cycles. It falls on the first cycle whose error reaches or passes the threshold. A large error catches a reference that drifts out of the tracking range or jumps in phase. A reference that stops sending strobes is caught by a tick watchdog, which clears the flag and the qualification run. The result is a slow, hard-to-fool "locked" indication that is quick to report trouble.

Top module: `hyst_lock_detect`

## Requirements
- R1: After reset, and until a full qualification run has been seen, `lock` is 0.
- R2: The phase error of a detector cycle is the number of sampling ticks, from the tick after the previous strobe up to and including the strobe tick, on which `up` or `dn` is 1. It saturates at 2^ERR_W-1.
- R3: A cycle is good only when its error is strictly less than `thresh`. An error equal to `thresh` is bad.
- R4: `lock` becomes 1 on the clock edge of the QUAL-th consecutive good evaluation (QUAL defaults to 8), and not before.
- R5: A single bad evaluation clears `lock` and the good-cycle run on that same edge.
- R6: The good-cycle run saturates at QUAL, so `lock` stays 1 through any number of further good evaluations.
- R7: If WD_TICKS clock edges pass with no strobe, `lock` and the run are cleared, and QUAL new good evaluations are needed before lock returns.
- R8: UP/DOWN activity between strobes does not change `lock`, apart from the watchdog action in R7.
- R9: A tick on which `up` and `dn` are both 1 adds one to the error, not two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up | input | 1 | Phase detector speed-up pulse, synchronous to clk |
| dn | input | 1 | Phase detector slow-down pulse, synchronous to clk |
| ref_tick | input | 1 | One-tick strobe that closes a detector cycle |
| thresh | input | ERR_W | Error limit in sampling ticks |
| lock | output | 1 | Qualified lock indication |

## Verification
The bench builds the block with ERR_W=6, QUAL=8 and WD_TICKS=200. The narrow error width lets one 70-tick pulse drive the accumulator into saturation, so the bench can compare the saturated value against a threshold equal to it. The short watchdog lets the bench reach a stopped-reference timeout and its recovery within a few hundred cycles. The run also covers pulses exactly at the threshold, overlapping UP/DOWN pulses, and a bad cycle that arrives just before qualification completes.

// File: rtl/hyst_lock_pkg.sv
package hyst_lock_pkg;

  // add a 0/1 step to a value, holding at a ceiling
  function automatic int unsigned sat_step(input int unsigned v,
                                           input int unsigned step,
                                           input int unsigned ceil);
    int unsigned s;
    s = v + step;
    return (s > ceil) ? ceil : s;
  endfunction

  // a detector cycle passes only when the error stays strictly under the limit
  function automatic bit err_in_window(input int unsigned err,
                                       input int unsigned limit);
    return err < limit;
  endfunction

endpackage

// File: rtl/hld_err_meter.sv
module hld_err_meter #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up,
  input  logic             dn,
  input  logic             ref_tick,
  output logic             ev_fire,
  output logic [ERR_W-1:0] ev_err
);
  import hyst_lock_pkg::*;

  localparam int unsigned ErrMax = (1 << ERR_W) - 1;

  logic [ERR_W-1:0] acc_q;
  logic             active;
  logic [ERR_W-1:0] acc_sum;

  assign active  = up | dn;
  assign acc_sum = ERR_W'(sat_step(32'(acc_q), 32'(active), ErrMax));

  assign ev_fire = ref_tick;
  assign ev_err  = acc_sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (ref_tick) acc_q <= '0;
    else               acc_q <= acc_sum;
  end
endmodule

// File: rtl/hld_watchdog.sv
module hld_watchdog #(
  parameter int WD_TICKS = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  output logic wd_fire
);
  localparam int WdW = (WD_TICKS > 1) ? $clog2(WD_TICKS) : 1;
  localparam logic [WdW-1:0] WdLast = WdW'(WD_TICKS - 1);

  logic [WdW-1:0] wd_q;

  assign wd_fire = !ref_tick && (wd_q == WdLast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  wd_q <= '0;
    else if (ref_tick || wd_fire) wd_q <= '0;
    else                         wd_q <= wd_q + 1'b1;
  end
endmodule

// File: rtl/hld_qualifier.sv
module hld_qualifier #(
  parameter int ERR_W = 8,
  parameter int QUAL  = 8,
  localparam int CntW = $clog2(QUAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_fire,
  input  logic [ERR_W-1:0] ev_err,
  input  logic [ERR_W-1:0] thresh,
  input  logic             wd_fire,
  output logic             ev_good,
  output logic [CntW-1:0]  good_cnt,
  output logic             lock_q
);
  import hyst_lock_pkg::*;

  localparam logic [CntW-1:0] CntFull = CntW'(QUAL);

  logic [CntW-1:0] cnt_next;

  assign ev_good  = err_in_window(32'(ev_err), 32'(thresh));
  assign cnt_next = CntW'(sat_step(32'(good_cnt), 32'd1, 32'(QUAL)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_cnt <= '0;
      lock_q   <= 1'b0;
    end else if (wd_fire) begin
      good_cnt <= '0;
      lock_q   <= 1'b0;
    end else if (ev_fire) begin
      if (ev_good) begin
        good_cnt <= cnt_next;
        lock_q   <= (cnt_next == CntFull);
      end else begin
        good_cnt <= '0;
        lock_q   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hyst_lock_detect.sv
module hyst_lock_detect #(
  parameter int ERR_W    = 8,
  parameter int QUAL     = 8,
  parameter int WD_TICKS = 65536
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up,
  input  logic             dn,
  input  logic             ref_tick,
  input  logic [ERR_W-1:0] thresh,
  output logic             lock
);
  localparam int CntW = $clog2(QUAL + 1);

  // named internal events, visible to the bound checker
  logic             ev_fire;
  logic [ERR_W-1:0] ev_err;
  logic             ev_good;
  logic             wd_fire;
  logic [CntW-1:0]  good_cnt;
  logic             lock_q;

  hld_err_meter #(.ERR_W(ERR_W)) u_meter (
    .clk(clk), .rst_n(rst_n), .up(up), .dn(dn), .ref_tick(ref_tick),
    .ev_fire(ev_fire), .ev_err(ev_err)
  );

  hld_watchdog #(.WD_TICKS(WD_TICKS)) u_wd (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wd_fire(wd_fire)
  );

  hld_qualifier #(.ERR_W(ERR_W), .QUAL(QUAL)) u_qual (
    .clk(clk), .rst_n(rst_n), .ev_fire(ev_fire), .ev_err(ev_err),
    .thresh(thresh), .wd_fire(wd_fire), .ev_good(ev_good),
    .good_cnt(good_cnt), .lock_q(lock_q)
  );

  assign lock = lock_q;
endmodule

// File: rtl/hyst_lock_detect_chk.sv
module hyst_lock_detect_chk #(
  parameter int QUAL = 8,
  localparam int CntW = $clog2(QUAL + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ev_fire,
  input logic            ev_good,
  input logic            wd_fire,
  input logic [CntW-1:0] good_cnt,
  input logic            lock
);
  // R5: a failing evaluation leaves lock low
  a_r5_bad_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && !ev_good) |=> !lock);

  // R5: a failing evaluation restarts the run
  a_r5_bad_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && !ev_good) |=> (good_cnt == '0));

  // R4: lock only rises on a good evaluation
  a_r4_rise_on_good: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(ev_fire && ev_good));

  // R4: lock is only held with a full run
  a_r4_lock_full_run: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> (good_cnt == CntW'(QUAL)));

  // R6: the run never passes its ceiling
  a_r6_run_capped: assert property (@(posedge clk) disable iff (!rst_n)
    good_cnt <= CntW'(QUAL));

  // R7: the watchdog clears everything
  a_r7_wd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> (!lock && good_cnt == '0));

  // R8: without an evaluation or watchdog, lock holds its value
  a_r8_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_fire && !wd_fire) |=> $stable(lock));
endmodule

bind hyst_lock_detect hyst_lock_detect_chk #(.QUAL(QUAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_fire(ev_fire), .ev_good(ev_good),
  .wd_fire(wd_fire), .good_cnt(good_cnt), .lock(lock)
);

// File: tb/hyst_lock_detect_tb.sv
module hyst_lock_detect_tb;
  localparam int ERR_W    = 6;
  localparam int QUAL     = 8;
  localparam int WD_TICKS = 200;
  localparam int ERR_MAX  = (1 << ERR_W) - 1;

  typedef struct {
    bit    lock;
    string tag;
  } exp_t;

  logic             clk = 0;
  logic             rst_n = 0;
  logic             up = 0, dn = 0, ref_tick = 0;
  logic [ERR_W-1:0] thresh = '0;
  logic             lock;

  int   total = 0, bad = 0;
  exp_t sb[$];
  int   mdl_run = 0;
  bit   mdl_lock = 0;

  hyst_lock_detect #(.ERR_W(ERR_W), .QUAL(QUAL), .WD_TICKS(WD_TICKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .up(up), .dn(dn), .ref_tick(ref_tick),
    .thresh(thresh), .lock(lock)
  );

  always #4 clk = ~clk;

  task automatic check(input bit act, input bit exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: lock=%0b expected %0b", tag, act, exp);
    end
  endtask

  // driver: one detector cycle; up high for up_w ticks, dn for dn_w, then strobe
  task automatic pd_cycle(input int up_w, input int dn_w, input string tag);
    int w, err;
    exp_t e;
    w = (up_w > dn_w) ? up_w : dn_w;
    for (int i = 0; i < w; i++) begin
      @(negedge clk);
      up = (i < up_w);
      dn = (i < dn_w);
    end
    @(negedge clk); up = 0; dn = 0;
    @(negedge clk); ref_tick = 1;
    err = (w > ERR_MAX) ? ERR_MAX : w;
    if (err < int'(thresh)) begin
      mdl_run = (mdl_run >= QUAL) ? QUAL : mdl_run + 1;
      mdl_lock = (mdl_run >= QUAL);
    end else begin
      mdl_run = 0;
      mdl_lock = 0;
    end
    e.lock = mdl_lock;
    e.tag  = tag;
    sb.push_back(e);
    @(negedge clk); ref_tick = 0;
  endtask

  // monitor: after each strobe edge, compare the lock flag with the queue head
  always @(posedge clk) begin
    if (rst_n && ref_tick) begin
      @(negedge clk);
      if (sb.size() == 0) begin
        total++; bad++;
        $display("FAIL R4: lock=%0b expected <none> (empty scoreboard)", lock);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(lock, e.lock, e.tag);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: lock=%0b expected run to end", lock);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none

    thresh = 6'd5;
    idle(3);
    check(lock, 0, "R1 reset");
    rst_n = 1;
    idle(2);
    check(lock, 0, "R1 after reset");

    // R4: seven good cycles stay unlocked, eighth locks
    for (int k = 0; k < 7; k++) pd_cycle(2, 0, "R4 pre-qual");
    pd_cycle(0, 3, "R4 eighth good locks");
    // R6: more good cycles keep lock
    for (int k = 0; k < 4; k++) pd_cycle(1, 0, "R6 stay locked");
    // R3: error equal to threshold is bad
    pd_cycle(5, 0, "R3 equal is bad / R5 drop");
    // R5: run restarts, bad on seventh good
    for (int k = 0; k < 7; k++) pd_cycle(4, 0, "R5 requalify");
    pd_cycle(9, 0, "R5 late bad");
    for (int k = 0; k < 8; k++) pd_cycle(4, 4, "R9 overlap counts once");
    // R9: up 3 dn 4 overlapped -> 4 < 5 good, lock held
    pd_cycle(3, 4, "R9 partial overlap");
    // R2: saturation; limit equals ERR_MAX
    thresh = 6'(ERR_MAX);
    pd_cycle(62, 0, "R2 just below ceiling");
    pd_cycle(70, 0, "R2 saturated equals limit");
    thresh = 6'd5;
    for (int k = 0; k < 8; k++) pd_cycle(0, 0, "R1 zero error");

    // R8/R7: quiet ticks; watchdog clears after WD_TICKS edges
    idle(WD_TICKS - 3);
    check(lock, 1, "R8 quiet hold");
    up = 1; idle(1); up = 0;
    check(lock, 1, "R8 pulse without strobe");
    idle(10);
    check(lock, 0, "R7 watchdog clears");
    mdl_run = 0; mdl_lock = 0;
    for (int k = 0; k < 8; k++) pd_cycle(1, 0, "R7 recovery");

    idle(5);
    if (sb.size() != 0) begin
      total++; bad++;
      $display("FAIL R4: lock=%0b expected all %0d pending results seen", lock, sb.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule